// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Burst SRAM Model

A synthesizable behavioural model of a synchronous, pipelined SRAM that needs no idle cycle between a read and a write. It is a target for memory-controller verification: a controller under test drives it cycle by cycle and gets the data timing of a real device of this kind. The model covers command capture, the two-bit burst address counter, the late write-data capture and the read pipeline. It leaves out electrical timing and power-down.

Every rising edge with `adv_i` low is a command edge. It loads a word address and the chip-enable and write-enable state. Every edge with `adv_i` high continues the running burst at the next address in linear or interleaved order. Both reads and writes have a two-edge data delay. Byte enables belong to the command edge, while the write word arrives two edges later. The shared data bus is split into a write-data input, a read-data output and a drive flag.

Top module: `psram_top`

## Requirements
- R1: On a rising edge with `adv_i`=0 the model loads `addr_i`, takes the operation as a read (`we_ni`=1) or a write (`we_ni`=0), and issues it at that address, provided `ce_ni`=0.
- R2: On a rising edge with `adv_i`=1 the model ignores `addr_i`, `ce_ni` and `we_ni`. It issues the same operation type as the last load, at the next burst address.
- R3: When `mode_i` was 0 at the load edge (linear), the low two address bits of beat k are (start+k) mod 4, and the upper bits stay at the loaded value. The counter wraps after the fourth beat.
- R4: When `mode_i` was 1 at the load edge (interleaved), the low two bits of beat k are start XOR (k mod 4). `mode_i` on advance edges has no effect.
- R5: Read data for an operation issued at edge t is held on `rdata_o` during the single cycle that follows edge t+2.
- R6: For a write issued at edge t, the word is taken from `wdata_i` at edge t+2. The byte enables are taken from `be_ni` at edge t.
- R7: The word is 36 bits. Lane n (n=0..3) is bits [8n+7:8n] plus bit 32+n. Active-low `be_ni[n]` writes or protects the lane as a whole.
- R8: `rdata_oe_o` = (a read result is due this cycle) AND NOT `oe_ni`. While `rdata_oe_o` is 0, `rdata_o` is all zeros.
- R9: A load edge with `ce_ni`=1 is a deselect. It moves no data, and the advance edges that follow it read and write nothing until the next load.
- R10: Reads and writes may be issued on consecutive edges in any mix. A read issued one or more edges after a write to the same word returns the newly written lanes.
- R11: After reset `rdata_oe_o` is 0, no burst is active, and every word reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable at load edges, active low |
| we_ni | input | 1 | Write (0) or read (1) at load edges |
| adv_i | input | 1 | 1 = advance burst, 0 = load new command |
| mode_i | input | 1 | Burst order at load edges: 0 linear, 1 interleaved |
| be_ni | input | LANES (4) | Byte-lane write enables, active low |
| addr_i | input | ADDR_W (6) | Word address |
| wdata_i | input | WORD_W (36) | Write word, taken two edges after its command |
| oe_ni | input | 1 | Output enable, active low, asynchronous |
| rdata_o | output | WORD_W (36) | Read word, zero when not driven |
| rdata_oe_o | output | 1 | Model drives the read word this cycle |

## Verification
Operations are issued at edge t. A write word is consumed at edge t+2, and a read result is visible between edges t+2 and t+3. The bench keeps a two-deep queue of issued operations and a reference array. At each edge it retires the oldest entry: it applies a write with the word it drove for that edge, or it computes the expected read from the array. Outputs are compared at the following falling edge, before the next inputs are driven. This means `oe_ni`, which acts without a clock, is checked with the value that was driven during that cycle. The burst address sequence is rebuilt in the bench from the start address, the beat count and the mode it latched at the load edge.

// File: rtl/psram_pkg.sv
package psram_pkg;
  localparam int unsigned BEAT_W = 2;

  // low address bits of a burst beat
  function automatic logic [BEAT_W-1:0] beat_off(input logic [BEAT_W-1:0] start,
                                                 input logic [BEAT_W-1:0] cnt,
                                                 input logic              ilv);
    return ilv ? (start ^ cnt) : (start + cnt);
  endfunction
endpackage

// File: rtl/psram_cmd.sv
module psram_cmd
  import psram_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              adv_i,
  input  logic              mode_i,
  input  logic [LANES-1:0]  be_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              op_vld_o,
  output logic              op_wr_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [LANES-1:0]  op_be_o
);
  localparam logic [ADDR_W-1:0] HI_MASK = ~ADDR_W'((1 << BEAT_W) - 1);

  logic [ADDR_W-1:0] base_q, beat_addr;
  logic [BEAT_W-1:0] cnt_q, cnt_nxt;
  logic              act_q, wr_q, ilv_q;

  assign cnt_nxt   = cnt_q + 1'b1;
  assign beat_addr = (base_q & HI_MASK) | ADDR_W'(beat_off(base_q[BEAT_W-1:0], cnt_nxt, ilv_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q    <= '0;
      cnt_q     <= '0;
      act_q     <= 1'b0;
      wr_q      <= 1'b0;
      ilv_q     <= 1'b0;
      op_vld_o  <= 1'b0;
      op_wr_o   <= 1'b0;
      op_addr_o <= '0;
      op_be_o   <= '0;
    end else if (!adv_i) begin
      base_q    <= addr_i;
      cnt_q     <= '0;
      act_q     <= ~ce_ni;
      wr_q      <= ~we_ni;
      ilv_q     <= mode_i;
      op_vld_o  <= ~ce_ni;
      op_wr_o   <= ~we_ni;
      op_addr_o <= addr_i;
      op_be_o   <= ~be_ni;
    end else begin
      cnt_q     <= cnt_nxt;
      op_vld_o  <= act_q;
      op_wr_o   <= wr_q;
      op_addr_o <= beat_addr;
      op_be_o   <= ~be_ni;
    end
  end

  // R2
  adv_keeps_type_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> (op_vld_o == $past(op_vld_o)) && (op_wr_o == $past(op_wr_o)));

  // R3
  adv_keeps_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> op_addr_o[ADDR_W-1:BEAT_W] == $past(op_addr_o[ADDR_W-1:BEAT_W]));
endmodule

// File: rtl/psram_dly.sv
module psram_dly #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/psram_array.sv
module psram_array #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_en_i,
  input  logic                              rd_en_i,
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic [LANES-1:0]                  be_i,
  input  logic [LANES*LANE_W+LANES-1:0]     wdata_i,
  output logic [LANES*LANE_W+LANES-1:0]     rdata_o,
  output logic                              rd_vld_o
);
  localparam int unsigned DEPTH  = 1 << ADDR_W;
  localparam int unsigned DATA_W = LANES * LANE_W;
  localparam int unsigned WORD_W = DATA_W + LANES;

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [WORD_W-1:0] lane_mask;

  for (genvar n = 0; n < LANES; n++) begin : g_lane
    assign lane_mask[n*LANE_W +: LANE_W] = {LANE_W{be_i[n]}};
    assign lane_mask[DATA_W + n]         = be_i[n];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      rdata_o  <= '0;
      rd_vld_o <= 1'b0;
    end else begin
      if (wr_en_i) mem_q[addr_i] <= (mem_q[addr_i] & ~lane_mask) | (wdata_i & lane_mask);
      rd_vld_o <= rd_en_i;
      if (rd_en_i) rdata_o <= mem_q[addr_i];
    end
  end

  // R7
  lane0_protect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !be_i[0]) |=> mem_q[$past(addr_i)][LANE_W-1:0] == $past(mem_q[addr_i][LANE_W-1:0]));
endmodule

// File: rtl/psram_top.sv
module psram_top #(
  parameter  int unsigned ADDR_W = 6,
  parameter  int unsigned LANES  = 4,
  parameter  int unsigned LANE_W = 8,
  localparam int unsigned WORD_W = LANES * LANE_W + LANES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              adv_i,
  input  logic              mode_i,
  input  logic [LANES-1:0]  be_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              oe_ni,
  output logic [WORD_W-1:0] rdata_o,
  output logic              rdata_oe_o
);
  localparam int unsigned OP_W = 2 + ADDR_W + LANES;

  logic              s1_vld, s1_wr, s2_vld, s2_wr, rd_vld;
  logic [ADDR_W-1:0] s1_addr, s2_addr;
  logic [LANES-1:0]  s1_be, s2_be;
  logic [WORD_W-1:0] rd_word;

  psram_cmd #(.ADDR_W(ADDR_W), .LANES(LANES)) cmd_i (
    .clk_i, .rst_ni, .ce_ni, .we_ni, .adv_i, .mode_i, .be_ni, .addr_i,
    .op_vld_o(s1_vld), .op_wr_o(s1_wr), .op_addr_o(s1_addr), .op_be_o(s1_be)
  );

  // second pipeline stage: aligns the command with its late write word
  psram_dly #(.W(OP_W)) stage2_i (
    .clk_i, .rst_ni,
    .d_i({s1_vld, s1_wr, s1_addr, s1_be}),
    .q_o({s2_vld, s2_wr, s2_addr, s2_be})
  );

  psram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) array_i (
    .clk_i, .rst_ni,
    .wr_en_i (s2_vld & s2_wr),
    .rd_en_i (s2_vld & ~s2_wr),
    .addr_i  (s2_addr),
    .be_i    (s2_be),
    .wdata_i (wdata_i),
    .rdata_o (rd_word),
    .rd_vld_o(rd_vld)
  );

  assign rdata_oe_o = rd_vld & ~oe_ni;
  assign rdata_o    = rdata_oe_o ? rd_word : '0;

  // R5
  rd_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !ce_ni && we_ni) |-> ##3 rd_vld);

  // R6
  wr_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !ce_ni && !we_ni) |-> ##2 (s2_vld && s2_wr));

  // R9
  dsel_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && ce_ni) |-> ##3 !rd_vld);

  // R8
  oe_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !rdata_oe_o && (rdata_o == '0));
endmodule

// File: tb/psram_top_tb_top.sv
module psram_top_tb_top;
  localparam int unsigned ADDR_W = 6;
  localparam int unsigned WORD_W = 36;

  typedef struct packed {
    logic              vld;
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [3:0]        be;
  } op_t;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              ce_ni = 1'b1, we_ni = 1'b1, adv_i = 1'b0, mode_i = 1'b0, oe_ni = 1'b0;
  logic [3:0]        be_ni = 4'hF;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [WORD_W-1:0] wdata_i = '0;
  logic [WORD_W-1:0] rdata_o;
  logic              rdata_oe_o;

  psram_top #(.ADDR_W(ADDR_W)) dut_i (
    .clk_i, .rst_ni, .ce_ni, .we_ni, .adv_i, .mode_i, .be_ni, .addr_i,
    .wdata_i, .oe_ni, .rdata_o, .rdata_oe_o
  );

  always #5 clk_i = ~clk_i;

  int unsigned       n_chk = 0, n_fail = 0;
  logic              done = 1'b0;
  logic [WORD_W-1:0] ref_mem [1 << ADDR_W];
  op_t               p1, p2;
  logic              exp_vld = 1'b0;
  logic [WORD_W-1:0] exp_dat = '0;
  logic              oe_drv = 1'b0;
  string             cur_tag = "R11";

  // bench burst state
  logic [ADDR_W-1:0] b_base = '0;
  logic [1:0]        b_cnt = '0;
  logic              b_act = 1'b0, b_wr = 1'b0, b_ilv = 1'b0;

  task automatic check_outputs();
    logic exp_oe;
    exp_oe = exp_vld & ~oe_ni;
    n_chk++;
    if (rdata_oe_o !== exp_oe) begin
      n_fail++;
      $display("FAIL R8 %s: rdata_oe_o=%0b expected %0b", cur_tag, rdata_oe_o, exp_oe);
    end
    n_chk++;
    if (exp_oe) begin
      if (rdata_o !== exp_dat) begin
        n_fail++;
        $display("FAIL R5 %s: rdata_o=%h expected %h", cur_tag, rdata_o, exp_dat);
      end
    end else if (rdata_o !== '0) begin
      n_fail++;
      $display("FAIL R8 %s: rdata_o=%h expected 0", cur_tag, rdata_o);
    end
  endtask

  task automatic step(input op_t nop, input logic ce, input logic we, input logic adv,
                      input logic mode, input logic [3:0] be, input logic [ADDR_W-1:0] a);
    check_outputs();
    ce_ni   = ce;
    we_ni   = we;
    adv_i   = adv;
    mode_i  = mode;
    be_ni   = be;
    addr_i  = a;
    oe_ni   = oe_drv;
    wdata_i = {$urandom(), $urandom()};
    @(posedge clk_i);
    #1;
    exp_vld = p2.vld && !p2.wr;
    if (exp_vld) exp_dat = ref_mem[p2.addr];
    if (p2.vld && p2.wr) begin
      for (int n = 0; n < 4; n++) begin
        if (p2.be[n]) begin
          ref_mem[p2.addr][n*8 +: 8] = wdata_i[n*8 +: 8];
          ref_mem[p2.addr][32 + n]   = wdata_i[32 + n];
        end
      end
    end
    p2 = p1;
    p1 = nop;
    @(negedge clk_i);
  endtask

  task automatic do_load(input logic ce, input logic we, input logic mode,
                         input logic [ADDR_W-1:0] a, input logic [3:0] be);
    op_t nop;
    nop   = '{vld: !ce, wr: !we, addr: a, be: ~be};
    b_act = !ce;
    b_wr  = !we;
    b_base = a;
    b_cnt = 2'd0;
    b_ilv = mode;
    step(nop, ce, we, 1'b0, mode, be, a);
  endtask

  task automatic do_adv(input logic [3:0] be);
    op_t        nop;
    logic [1:0] off;
    b_cnt = b_cnt + 2'd1;
    off   = b_ilv ? (b_base[1:0] ^ b_cnt) : (b_base[1:0] + b_cnt);
    nop   = '{vld: b_act, wr: b_wr, addr: {b_base[ADDR_W-1:2], off}, be: ~be};
    // ce, we, mode and address are noise on advance edges (R2, R4)
    step(nop, 1'($urandom()), 1'($urandom()), 1'b1, 1'($urandom()), be, ADDR_W'($urandom()));
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) do_load(1'b1, 1'b1, 1'b0, '0, 4'hF);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < (1 << ADDR_W); i++) ref_mem[i] = '0;
    p1 = '0;
    p2 = '0;
    repeat (3) @(negedge clk_i);
    // R11: no read driven during reset
    n_chk++;
    if (rdata_oe_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R11: rdata_oe_o=%0b expected 0", rdata_oe_o);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R11: array zero after reset; R1 single read
    cur_tag = "R11 R1";
    do_load(1'b0, 1'b1, 1'b0, 6'd3, 4'hF);
    idle(3);

    // R3 R6: linear burst write from low bits 2, then read back
    cur_tag = "R3 R6";
    do_load(1'b0, 1'b0, 1'b0, 6'd6, 4'h0);
    repeat (3) do_adv(4'h0);
    idle(2);
    do_load(1'b0, 1'b1, 1'b0, 6'd6, 4'hF);
    repeat (5) do_adv(4'hF);
    idle(3);

    // R7: partial lane write (lanes 0 and 2 enabled), then read
    cur_tag = "R7";
    do_load(1'b0, 1'b0, 1'b0, 6'd9, 4'b1010);
    idle(2);
    do_load(1'b0, 1'b1, 1'b0, 6'd9, 4'hF);
    idle(3);

    // R4: interleaved burst write and read from low bits 1
    cur_tag = "R4";
    do_load(1'b0, 1'b0, 1'b1, 6'd21, 4'h0);
    repeat (3) do_adv(4'h0);
    do_load(1'b0, 1'b1, 1'b1, 6'd21, 4'hF);
    repeat (3) do_adv(4'hF);
    do_load(1'b0, 1'b1, 1'b0, 6'd21, 4'hF);
    repeat (3) do_adv(4'hF);
    idle(3);

    // R9: deselect followed by advances does nothing
    cur_tag = "R9";
    do_load(1'b1, 1'b0, 1'b0, 6'd6, 4'h0);
    repeat (4) do_adv(4'h0);
    idle(2);
    do_load(1'b0, 1'b1, 1'b0, 6'd6, 4'hF);
    repeat (3) do_adv(4'hF);
    idle(3);

    // R10: back-to-back write then read of same word
    cur_tag = "R10";
    do_load(1'b0, 1'b0, 1'b0, 6'd12, 4'h0);
    do_load(1'b0, 1'b1, 1'b0, 6'd12, 4'hF);
    do_load(1'b0, 1'b0, 1'b0, 6'd12, 4'b0110);
    do_load(1'b0, 1'b1, 1'b0, 6'd12, 4'hF);
    idle(3);

    // R8: read with output enable high
    cur_tag = "R8";
    do_load(1'b0, 1'b1, 1'b0, 6'd12, 4'hF);
    do_load(1'b0, 1'b1, 1'b0, 6'd6, 4'hF);
    oe_drv = 1'b1;
    idle(1);
    oe_drv = 1'b0;
    idle(3);

    // random mix
    cur_tag = "R1 R2 R3 R4 R6 R7 R10";
    for (int i = 0; i < 3000; i++) begin
      oe_drv = ($urandom() % 4) == 0;
      if (($urandom() % 10) < 6) do_adv(4'($urandom()));
      else do_load(($urandom() % 8) == 0, 1'($urandom()), 1'($urandom()),
                   ADDR_W'($urandom()), 4'($urandom()));
    end
    oe_drv = 1'b0;
    idle(3);
    check_outputs();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual not done expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule